// File: doc/BRIEF.md
# Receive Byte Queue with Programmable Fill Threshold

This block sits between a serial receiver and a register bus. Each byte the receiver delivers is stored in a 16-entry circular queue. A data-ready flag and a receive interrupt come up when the number of stored bytes reaches a selectable threshold. Software drains the queue through a data port. Each read strobe removes the oldest byte. The current occupancy is always visible.

Two register writes configure the block. The queue control write selects the threshold and can empty the queue. The serial control write holds the receive-enable bit and the interrupt-enable bit.

Occupancy is tracked by a three-state controller:
- `S_EMPTY`: nothing is stored.
- `S_PART`: between one and fifteen bytes are stored.
- `S_FULL`: sixteen bytes are stored.

The transitions are:
- `fill`: `S_EMPTY` to `S_PART`, taken on an accepted byte.
- `top`: `S_PART` to `S_FULL`, taken when the count reaches 16.
- `drain`: `S_PART` to `S_EMPTY`, taken when the count reaches 0.
- `spill`: `S_FULL` to `S_PART`, taken on a read.
- `flush`: any state to `S_EMPTY`, taken on a queue reset.

Top module: `rxq_trig_fifo`

## Requirements
- R1: Bytes leave in the order they arrived. Storage is 16 entries, and the write and read positions wrap from 15 back to 0.
- R2: On a queue control write, bits 7:6 select the threshold: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 entries. The new threshold applies from the next cycle.
- R3: When an accepted byte brings the count to the threshold or above, `full_flag` is set. If interrupt enable (serial control bit 6) is 1, `rx_irq` is set as well.
- R4: A byte offered while 16 entries are held is dropped, and the count and the contents are unchanged.
- R5: While the count is nonzero, `rx_data` shows the oldest byte. A read strobe removes that byte and decrements the count. If the new count is below the threshold, `full_flag` and `rx_irq` are cleared.
- R6: A queue control write with bit 1 set empties the queue and clears `full_flag` and `rx_irq`. A byte or read strobe arriving in the same cycle is ignored.
- R7: Bytes are accepted only while receive enable (serial control bit 4) is 1. `fill_cnt` always shows the current count.
- R8: After reset the queue is empty, the threshold is 1, both enables are 0, and `full_flag`, `rx_irq` and `rx_data` are 0.
- R9: While the queue is empty, `rx_data` is 0, and a read strobe changes nothing.
- R10: An accepted byte and a read in the same cycle leave the count unchanged and advance both positions.
- R11: A serial control write with bit 6 clear drops `rx_irq` at the same clock edge that clears the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Receiver byte strobe |
| rx_byte | input | 8 | Received byte |
| rd_pop | input | 1 | Data port read strobe |
| fctl_we | input | 1 | Queue control write strobe |
| fctl_wdata | input | 8 | Queue control write data |
| sctl_we | input | 1 | Serial control write strobe |
| sctl_wdata | input | 8 | Serial control write data |
| rx_data | output | 8 | Oldest stored byte, 0 when empty |
| fill_cnt | output | 5 | Number of stored bytes |
| full_flag | output | 1 | Threshold-reached flag |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The queue is filled and drained under each of the four thresholds. This separates a wrong threshold decode from a wrong comparison, because the flag must rise exactly on the byte that reaches the level and fall on the read that goes below it.

A burst of twenty bytes at threshold 14 overruns the queue after the positions have already wrapped. This shows whether dropped bytes corrupt the order.

Separate patterns cover the remaining cases:
- simultaneous byte and read
- a read on an empty queue
- bytes offered with receive disabled
- a flush colliding with traffic
- the interrupt enable being withdrawn while the interrupt is high

Each of these isolates one gating term.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [1:0] {
        S_EMPTY = 2'd0,
        S_PART  = 2'd1,
        S_FULL  = 2'd2
    } occ_e;

    // Threshold code to entry count, scaled from the queue depth (R2)
    function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
        case (sel)
            2'b00:   return 1;
            2'b01:   return depth / 4;
            2'b10:   return depth / 2;
            default: return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          do_push,
    input  logic          do_pop,
    input  logic          flush,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head_byte
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= step_ptr(wr_ptr);
            if (do_pop)  rd_ptr <= step_ptr(rd_ptr);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    assign head_byte = mem[rd_ptr];

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic          pop_req,
    input  logic          fctl_we,
    input  logic [1:0]    trig_sel,
    input  logic          flush_bit,
    input  logic          sctl_we,
    input  logic          ie_bit,
    input  logic          en_bit,
    output logic          do_push,
    output logic          do_pop,
    output logic          flush,
    output logic [CW-1:0] count,
    output logic          full_flag,
    output logic          irq,
    output logic          rx_en
);

    occ_e          st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] trig_q;
    logic          flag_q, flag_d;
    logic          irq_q, irq_d;
    logic          rx_en_q, ie_q;

    assign flush   = fctl_we & flush_bit;
    assign do_push = push_req & rx_en_q & (st_q != S_FULL) & ~flush;
    assign do_pop  = pop_req & (st_q != S_EMPTY) & ~flush;

    always_comb begin
        cnt_d = cnt_q;
        if (flush)
            cnt_d = '0;
        else if (do_push && !do_pop)
            cnt_d = cnt_q + CW'(1);
        else if (do_pop && !do_push)
            cnt_d = cnt_q - CW'(1);
    end

    // Next occupancy state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_EMPTY: if (do_push)                     st_d = (cnt_d == CW'(DEPTH)) ? S_FULL : S_PART;
            S_PART:  if (cnt_d == '0)                 st_d = S_EMPTY;
                     else if (cnt_d == CW'(DEPTH))    st_d = S_FULL;
            S_FULL:  if (do_pop)                      st_d = S_PART;
            default:                                  st_d = S_EMPTY;
        endcase
        if (flush) st_d = S_EMPTY;
    end

    // Flag and interrupt next values
    always_comb begin
        flag_d = flag_q;
        irq_d  = irq_q;
        if (flush) begin
            flag_d = 1'b0;
            irq_d  = 1'b0;
        end else if (do_push && cnt_d >= trig_q) begin
            flag_d = 1'b1;
            if (ie_q) irq_d = 1'b1;
        end else if (do_pop && cnt_d < trig_q) begin
            flag_d = 1'b0;
            irq_d  = 1'b0;
        end
        if (sctl_we && !ie_bit) irq_d = 1'b0;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_EMPTY;
        else        st_q <= st_d;
    end

    // Output and configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            trig_q  <= CW'(1);
            flag_q  <= 1'b0;
            irq_q   <= 1'b0;
            rx_en_q <= 1'b0;
            ie_q    <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            flag_q <= flag_d;
            irq_q  <= irq_d;
            if (fctl_we) trig_q <= CW'(trig_level(trig_sel, DEPTH));
            if (sctl_we) begin
                rx_en_q <= en_bit;
                ie_q    <= ie_bit;
            end
        end
    end

    assign count     = cnt_q;
    assign full_flag = flag_q;
    assign irq       = irq_q;
    assign rx_en     = rx_en_q;

endmodule

// File: rtl/rxq_trig_fifo.sv
module rxq_trig_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 8,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    input  logic          rd_pop,
    input  logic          fctl_we,
    input  logic [7:0]    fctl_wdata,
    input  logic          sctl_we,
    input  logic [7:0]    sctl_wdata,
    output logic [DW-1:0] rx_data,
    output logic [CW-1:0] fill_cnt,
    output logic          full_flag,
    output logic          rx_irq
);

    logic          do_push, do_pop, flush, rx_en_w;
    logic [DW-1:0] head_byte;
    logic          unused_bits;

    assign unused_bits = ^{fctl_wdata[5:2], fctl_wdata[0], sctl_wdata[7],
                           sctl_wdata[5], sctl_wdata[3:0]};

    rxq_ctrl #(.DEPTH(DEPTH)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (rx_valid),
        .pop_req   (rd_pop),
        .fctl_we   (fctl_we),
        .trig_sel  (fctl_wdata[7:6]),
        .flush_bit (fctl_wdata[1]),
        .sctl_we   (sctl_we),
        .ie_bit    (sctl_wdata[6]),
        .en_bit    (sctl_wdata[4]),
        .do_push   (do_push),
        .do_pop    (do_pop),
        .flush     (flush),
        .count     (fill_cnt),
        .full_flag (full_flag),
        .irq       (rx_irq),
        .rx_en     (rx_en_w)
    );

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_push   (do_push),
        .do_pop    (do_pop),
        .flush     (flush),
        .wdata     (rx_byte),
        .head_byte (head_byte)
    );

    assign rx_data = (fill_cnt != '0) ? head_byte : '0;

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 8,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic          rd_pop,
    input logic          fctl_we,
    input logic [7:0]    fctl_wdata,
    input logic          sctl_we,
    input logic [7:0]    sctl_wdata,
    input logic          rx_en,
    input logic [DW-1:0] rx_data,
    input logic [CW-1:0] fill_cnt,
    input logic          full_flag,
    input logic          rx_irq
);

    // R4
    overflow_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_cnt == CW'(DEPTH) && rx_valid && rx_en && !rd_pop && !fctl_we)
        |=> $stable(fill_cnt));

    // R6
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fctl_we && fctl_wdata[1]) |=> (fill_cnt == '0 && !full_flag && !rx_irq));

    // R3
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> full_flag);

    // R11
    ie_clear_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sctl_we && !sctl_wdata[6]) |=> !rx_irq);

    // R9
    empty_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_cnt == '0) |-> (rx_data == '0));

    // R10
    push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_en && rd_pop && !fctl_we && fill_cnt != '0 && fill_cnt != CW'(DEPTH))
        |=> $stable(fill_cnt));

endmodule

bind rxq_trig_fifo rxq_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rd_pop     (rd_pop),
    .fctl_we    (fctl_we),
    .fctl_wdata (fctl_wdata),
    .sctl_we    (sctl_we),
    .sctl_wdata (sctl_wdata),
    .rx_en      (rx_en_w),
    .rx_data    (rx_data),
    .fill_cnt   (fill_cnt),
    .full_flag  (full_flag),
    .rx_irq     (rx_irq)
);

// File: tb/test_rxq_trig_fifo.sv
module test_rxq_trig_fifo;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rd_pop = 1'b0;
    logic       fctl_we = 1'b0;
    logic [7:0] fctl_wdata = '0;
    logic       sctl_we = 1'b0;
    logic [7:0] sctl_wdata = '0;
    logic [7:0] rx_data;
    logic [4:0] fill_cnt;
    logic       full_flag;
    logic       rx_irq;

    always #5 clk = ~clk;

    rxq_trig_fifo i_rxq_trig_fifo (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rd_pop(rd_pop), .fctl_we(fctl_we), .fctl_wdata(fctl_wdata),
        .sctl_we(sctl_we), .sctl_wdata(sctl_wdata), .rx_data(rx_data),
        .fill_cnt(fill_cnt), .full_flag(full_flag), .rx_irq(rx_irq)
    );

    int    total = 0;
    int    fails = 0;
    bit    done = 0;
    string tag = "R8";

    // Reference state
    byte unsigned q[$];
    int  m_trig = 1;
    bit  m_en = 0, m_ie = 0, m_flag = 0, m_irq = 0;

    task automatic chk(input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("fill_cnt", int'(fill_cnt), q.size());
        chk("full_flag", int'(full_flag), int'(m_flag));
        chk("rx_irq", int'(rx_irq), int'(m_irq));
        chk("rx_data", int'(rx_data), (q.size() > 0) ? int'(q[0]) : 0);
    endtask

    function automatic int decode(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    // One clock: compare, drive, update model
    task automatic step(input bit v, input logic [7:0] b, input bit pop,
                        input bit fwe, input logic [7:0] fd,
                        input bit swe, input logic [7:0] sd);
        bit fl, push_ok, pop_ok;
        int n;
        compare();
        rx_valid = v; rx_byte = b; rd_pop = pop;
        fctl_we = fwe; fctl_wdata = fd; sctl_we = swe; sctl_wdata = sd;
        @(posedge clk);
        fl      = fwe && fd[1];
        push_ok = v && m_en && q.size() < 16 && !fl;
        pop_ok  = pop && q.size() > 0 && !fl;
        if (fl) begin
            q.delete(); m_flag = 0; m_irq = 0;
        end else begin
            if (pop_ok) void'(q.pop_front());
            if (push_ok) q.push_back(b);
            n = q.size();
            if (push_ok && n >= m_trig) begin
                m_flag = 1;
                if (m_ie) m_irq = 1;
            end else if (pop_ok && n < m_trig) begin
                m_flag = 0; m_irq = 0;
            end
        end
        if (fwe) m_trig = decode(fd[7:6]);
        if (swe) begin
            m_en = sd[4]; m_ie = sd[6];
            if (!sd[6]) m_irq = 0;
        end
        @(negedge clk);
        rx_valid = 0; rd_pop = 0; fctl_we = 0; sctl_we = 0;
    endtask

    task automatic push(input logic [7:0] b); step(1, b, 0, 0, 0, 0, 0); endtask
    task automatic pop1();                   step(0, 0, 1, 0, 0, 0, 0); endtask
    task automatic fctl(input logic [7:0] d); step(0, 0, 0, 1, d, 0, 0); endtask
    task automatic sctl(input logic [7:0] d); step(0, 0, 0, 0, 0, 1, d); endtask
    task automatic idle();                   step(0, 0, 0, 0, 0, 0, 0); endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; total++;
            $display("FAIL watchdog act=0 exp=1");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tag = "R8"; idle();
        tag = "R9"; pop1(); idle();
        tag = "R7"; push(8'h11); push(8'h12); idle();
        sctl(8'h50);
        tag = "R3"; push(8'hA1); idle(); push(8'hA2); idle();
        tag = "R5"; pop1(); pop1(); idle();
        tag = "R2"; fctl(8'h40);
        for (int i = 0; i < 4; i++) push(8'h20 + 8'(i));
        idle();
        tag = "R5"; pop1(); idle(); pop1(); idle();
        tag = "R2"; fctl(8'h80);
        for (int i = 0; i < 9; i++) push(8'h40 + 8'(i));
        tag = "R6"; step(1, 8'hEE, 1, 1, 8'h82, 0, 0); idle();
        tag = "R4"; fctl(8'hC0);
        for (int i = 0; i < 20; i++) push(8'h60 + 8'(i));
        idle();
        tag = "R1";
        for (int i = 0; i < 16; i++) pop1();
        idle();
        tag = "R9"; pop1(); idle();
        tag = "R10"; fctl(8'h00); push(8'h71); push(8'h72);
        for (int i = 0; i < 5; i++) step(1, 8'h80 + 8'(i), 1, 0, 0, 0, 0);
        idle();
        tag = "R4"; fctl(8'h02);
        for (int i = 0; i < 16; i++) push(8'h90 + 8'(i));
        step(1, 8'hFF, 1, 0, 0, 0, 0); idle();
        tag = "R11"; fctl(8'h02); push(8'h55); idle();
        sctl(8'h10); idle(); push(8'h56); idle();
        tag = "R7"; sctl(8'h00); push(8'h57); idle();
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule